// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase bridge (U, V and W, each with an upper and a lower switch). A single 12-bit counter runs either as a sawtooth for edge-aligned PWM or as an up/down triangle for center-aligned PWM. Each phase compares the counter against its own active compare value. The result becomes a complementary pair of gate signals. A programmable dead time is placed in front of every turn-on, and each side has a selectable output polarity.

The period and the three compare values are written into shadow registers. They move into the active copies only at the period boundary, so software can change duty and frequency while the generator runs without producing a torn pulse. A duty-sharing bit lets the U compare value drive all three phases. An interrupt pulse is raised once every 1, 2, 4 or 8 periods. In center mode it can also be raised at the triangle peak.

Software uses a single-cycle write strobe and a combinational read port. The counter value and the count direction can be read back but not written.

Top module: `pwm3_gen`

## Requirements
- R1: After reset every register reads 0, the counter and direction flag are 0, `irq` is low and all six gates are low.
- R2: Address map: 0 control, 1 period, 2/3/4 U/V/W compare, 5 dead time, 6 counter (read-only), 7 status (bit 0 = direction). Control bits: [0] run, [1] center mode, [2] shared duty, [4:3] interrupt rate, [5] half-period interrupt, [6] upper active-low, [7] lower active-low. In edge mode (bit 1 = 0) with active period P, the counter steps 0,1,…,P and then returns to 0, giving P+1 clocks per period.
- R3: In center mode the counter steps up from 0 to P and then down to 1. The next value is 0 and it climbs again, giving 2P clocks per period (P ≥ 1).
- R4: The direction flag is 1 from the clock after the peak until the counter returns to 0. It is 0 at all times in edge mode.
- R5: A period write goes to the shadow only. The active period takes the shadow value on the clock where the counter returns to 0, and on every clock while run is 0.
- R6: Compare writes are buffered in the same way as period writes. A phase's raw level is high while the counter is below its active compare value.
- R7: While shared duty is 1 at a load, the U compare shadow is loaded into all three active compare values.
- R8: `irq` is a one-clock pulse, in the clock where the counter shows 0, after every 2^rate-th period end counted from when run was set.
- R9: In center mode with rate 0 and the half-period bit set, `irq` also pulses in the clock after the peak.
- R10: Each phase samples its raw level once per clock. An output turns on only after its level has been held for the dead-time count of further clocks. It turns off at once, and the upper and lower outputs are never on together.
- R11: While run is 0 the counter and direction are held at 0 and both outputs of every phase are off.
- R12: A polarity bit set to 1 inverts its gate outputs. A control write made while run is 1 leaves both polarity bits unchanged.
- R13: Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 12 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 12 | Read data, combinational |
| gate_hi | output | 3 | Upper gate outputs, bit 0 = U |
| gate_lo | output | 3 | Lower gate outputs, bit 0 = U |
| cnt_down | output | 1 | Counter direction flag |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong counter step or direction shows up at the read port and on `cnt_down` in the same clock. The first misplaced reload shows on the gates within one period. A corrupted active compare or period value shows as a moved gate edge, at the latest one clock after the counter crosses the value. A dead-time counter that is off shows as a gate edge that comes early or late in the first transition after the fault. A wrong period divider is seen at the next expected interrupt, which is at most eight periods away.

// File: rtl/pwm3_pkg.sv
// Shared definitions for the three-phase PWM generator: control word
// layout and register addresses.
package pwm3_pkg;

    localparam int ADDR_W   = 3;
    localparam int RATE_W   = 2;

    localparam int ADR_CTRL = 0;
    localparam int ADR_PRD  = 1;
    localparam int ADR_CMP0 = 2;   // phases occupy ADR_CMP0 .. ADR_CMP0+2
    localparam int ADR_DEAD = 5;
    localparam int ADR_CNT  = 6;
    localparam int ADR_STAT = 7;

    // Control word, bit 0 first from the bottom.
    typedef struct packed {
        logic              pol_l;   // [7] lower side active low
        logic              pol_h;   // [6] upper side active low
        logic              half;    // [5] extra interrupt at the peak
        logic [RATE_W-1:0] rate;    // [4:3] interrupt every 2^rate periods
        logic              common;  // [2] U compare drives all phases
        logic              center;  // [1] triangle counting
        logic              en;      // [0] run
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm3_regs.sv
// Register file of the PWM generator: control word, period shadow,
// compare shadows and dead time, plus the combinational read mux.
// Assumes CNT_W >= CTRL_W, CNT_W >= DT_W and three phases in the map.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8,
    parameter int NPH   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic                      dir_i,
    output ctrl_t                     ctrl_o,
    output logic [CNT_W-1:0]          prd_sh_o,
    output logic [NPH-1:0][CNT_W-1:0] cmp_sh_o,
    output logic [DT_W-1:0]           dt_o,
    output logic [CNT_W-1:0]          rd_data
);

    ctrl_t                     ctrl_q, ctrl_nxt;
    logic [CNT_W-1:0]          prd_q;
    logic [NPH-1:0][CNT_W-1:0] cmp_q;
    logic [DT_W-1:0]           dt_q;

    // Next control word: polarity is frozen while the generator runs.
    always_comb begin
        ctrl_nxt = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (ctrl_q.en) begin
            ctrl_nxt.pol_h = ctrl_q.pol_h;
            ctrl_nxt.pol_l = ctrl_q.pol_l;
        end
    end

    // Register writes; counter and status addresses are not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            prd_q  <= '0;
            cmp_q  <= '0;
            dt_q   <= '0;
        end else if (wr_en) begin
            if (int'(wr_addr) == ADR_CTRL) ctrl_q <= ctrl_nxt;
            if (int'(wr_addr) == ADR_PRD)  prd_q  <= wr_data;
            if (int'(wr_addr) == ADR_DEAD) dt_q   <= wr_data[DT_W-1:0];
            for (int i = 0; i < NPH; i++) begin
                if (int'(wr_addr) == ADR_CMP0 + i) cmp_q[i] <= wr_data;
            end
        end
    end

    // Read mux over stored registers and live counter state.
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == ADR_CTRL) rd_data = CNT_W'(ctrl_q);
        if (int'(rd_addr) == ADR_PRD)  rd_data = prd_q;
        if (int'(rd_addr) == ADR_DEAD) rd_data = CNT_W'(dt_q);
        if (int'(rd_addr) == ADR_CNT)  rd_data = cnt_i;
        if (int'(rd_addr) == ADR_STAT) rd_data = CNT_W'(dir_i);
        for (int i = 0; i < NPH; i++) begin
            if (int'(rd_addr) == ADR_CMP0 + i) rd_data = cmp_q[i];
        end
    end

    assign ctrl_o   = ctrl_q;
    assign prd_sh_o = prd_q;
    assign cmp_sh_o = cmp_q;
    assign dt_o     = dt_q;

    AST_POL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_q.en) |-> $stable(ctrl_q.pol_h) && $stable(ctrl_q.pol_l)); // R12

endmodule

// File: rtl/pwm3_counter.sv
// Shared PWM time base: sawtooth or triangle counter, direction flag,
// double-buffered period and the decimated interrupt pulse.
// Assumes the period is loaded only where the counter restarts at 0.
module pwm3_counter
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              center_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              half_i,
    input  logic [CNT_W-1:0]  prd_sh_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_o,
    output logic              load_o,
    output logic              irq_o
);

    localparam int              DIV_W = (1 << RATE_W) - 1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_n, prd_act_q;
    logic             dir_q, dir_n, wrap, peak, irq_q, irq_n;
    logic [DIV_W-1:0] div_q, mask;
    logic [DIV_W:0]   span;

    // Next counter value, direction and boundary events.
    always_comb begin
        cnt_n = cnt_q;
        dir_n = dir_q;
        wrap  = 1'b0;
        peak  = 1'b0;
        if (!en_i) begin
            cnt_n = '0;
            dir_n = 1'b0;
        end else if (!center_i) begin
            dir_n = 1'b0;
            if (cnt_q >= prd_act_q) begin
                wrap  = 1'b1;
                cnt_n = '0;
            end else begin
                cnt_n = cnt_q + ONE;
            end
        end else if (!dir_q) begin
            if (cnt_q >= prd_act_q) begin
                peak = 1'b1;
                if (cnt_q <= ONE) begin
                    wrap  = 1'b1;
                    cnt_n = '0;
                    dir_n = 1'b0;
                end else begin
                    cnt_n = cnt_q - ONE;
                    dir_n = 1'b1;
                end
            end else begin
                cnt_n = cnt_q + ONE;
            end
        end else begin
            if (cnt_q <= ONE) begin
                wrap  = 1'b1;
                cnt_n = '0;
                dir_n = 1'b0;
            end else begin
                cnt_n = cnt_q - ONE;
            end
        end
    end

    // Interrupt decision from the period divider and the peak option.
    always_comb begin
        span  = ({{DIV_W{1'b0}}, 1'b1} << rate_i) - 1'b1;
        mask  = span[DIV_W-1:0];
        irq_n = en_i && ((wrap && ((div_q & mask) == mask)) ||
                         (peak && half_i && (rate_i == '0)));
    end

    // Counter, direction, active period and divider state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            dir_q     <= 1'b0;
            prd_act_q <= '0;
            div_q     <= '0;
            irq_q     <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            dir_q <= dir_n;
            irq_q <= irq_n;
            if (load_o)     prd_act_q <= prd_sh_i;
            if (!en_i)      div_q     <= '0;
            else if (wrap)  div_q     <= div_q + 1'b1;
        end
    end

    assign load_o = !en_i || wrap;
    assign cnt_o  = cnt_q;
    assign dir_o  = dir_q;
    assign irq_o  = irq_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= prd_act_q); // R2
    AST_EDGE_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!center_i) |-> !dir_q); // R4
    AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$past(wrap) |-> $stable(prd_act_q)); // R5
    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(en_i)); // R8

endmodule

// File: rtl/pwm3_phase.sv
// One phase: active compare buffer, comparator, dead-time insertion
// and output polarity. Assumes load_i marks the period boundary.
module pwm3_phase #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cmp_src_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [DT_W-1:0]  dt_i,
    input  logic             pol_h_i,
    input  logic             pol_l_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o
);

    localparam logic [DT_W-1:0] RUN_MAX = '1;

    logic [CNT_W-1:0] cmp_act_q;
    logic [DT_W-1:0]  run_q;
    logic             lvl_q, raw, settled, act_hi, act_lo;

    assign raw = cnt_i < cmp_act_q;

    // Active compare value, reloaded only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_act_q <= '0;
        else if (load_i) cmp_act_q <= cmp_src_i;
    end

    // Sampled level and the clocks it has been held, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else begin
            lvl_q <= raw;
            if (raw != lvl_q)        run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    // Turn-on waits for the dead time; turn-off follows the level.
    always_comb begin
        settled = run_q >= dt_i;
        act_hi  = en_i &&  lvl_q && settled;
        act_lo  = en_i && !lvl_q && settled;
    end

    assign gate_hi_o = act_hi ^ pol_h_i;
    assign gate_lo_o = act_lo ^ pol_l_i;

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!load_i) |-> $stable(cmp_act_q)); // R6
    AST_TURN_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_hi) && (dt_i != '0) |-> $past(!act_lo)); // R10

endmodule

// File: rtl/pwm3_gen.sv
// Top of the three-phase PWM generator: register file, shared time
// base and one phase slice per output pair.
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8,
    parameter int NPH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NPH-1:0]    gate_hi,
    output logic [NPH-1:0]    gate_lo,
    output logic              cnt_down,
    output logic              irq
);

    ctrl_t                     ctrl;
    logic [CNT_W-1:0]          prd_sh, cnt;
    logic [NPH-1:0][CNT_W-1:0] cmp_sh;
    logic [DT_W-1:0]           dt;
    logic                      dir, load;

    pwm3_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt_i    (cnt),
        .dir_i    (dir),
        .ctrl_o   (ctrl),
        .prd_sh_o (prd_sh),
        .cmp_sh_o (cmp_sh),
        .dt_o     (dt),
        .rd_data  (rd_data)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl.en),
        .center_i (ctrl.center),
        .rate_i   (ctrl.rate),
        .half_i   (ctrl.half),
        .prd_sh_i (prd_sh),
        .cnt_o    (cnt),
        .dir_o    (dir),
        .load_o   (load),
        .irq_o    (irq)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic [CNT_W-1:0] cmp_src;
        // Shared duty routes the U shadow to every phase.
        assign cmp_src = ctrl.common ? cmp_sh[0] : cmp_sh[p];

        pwm3_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ctrl.en),
            .load_i    (load),
            .cmp_src_i (cmp_src),
            .cnt_i     (cnt),
            .dt_i      (dt),
            .pol_h_i   (ctrl.pol_h),
            .pol_l_i   (ctrl.pol_l),
            .gate_hi_o (gate_hi[p]),
            .gate_lo_o (gate_lo[p])
        );
    end

    assign cnt_down = dir;

endmodule

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;

    localparam int HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd6;
    logic [11:0] rd_data;
    logic [2:0]  gate_hi, gate_lo;
    logic        cnt_down, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string scen = "R1";

    always #HALF clk = ~clk;

    pwm3_gen u_pwm3_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .cnt_down(cnt_down), .irq(irq)
    );

    typedef struct {
        logic [2:0]  hi, lo;
        logic        dir, irq, cen;
        logic [11:0] cnt;
    } exp_t;
    exp_t q[$];

    // Reference state built from the requirements.
    logic [7:0]  m_ctrl, n_ctrl;
    logic [11:0] m_prd_sh, m_prd, m_cnt, n_cnt;
    logic [11:0] m_cmp_sh [3];
    logic [11:0] m_cmp [3];
    logic [7:0]  m_dt;
    logic [7:0]  m_run [3];
    logic [2:0]  m_lvl, m_div;
    logic        m_dir, m_irq, n_dir, wrap, peak, ld, raw;
    int          mask;

    task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] got %h expected %h at %0t", tag, scen, got, exp, $time);
        end
    endtask

    // Reference model: steps at each edge and pushes the expected outputs.
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            m_ctrl = 0; m_prd_sh = 0; m_prd = 0; m_cnt = 0; m_dt = 0;
            m_dir = 0; m_irq = 0; m_div = 0; m_lvl = 0;
            for (int i = 0; i < 3; i++) begin
                m_cmp_sh[i] = 0; m_cmp[i] = 0; m_run[i] = 0;
            end
        end else begin
            wrap = 0; peak = 0; n_cnt = m_cnt; n_dir = m_dir;
            if (!m_ctrl[0]) begin n_cnt = 0; n_dir = 0; end
            else if (!m_ctrl[1]) begin
                n_dir = 0;
                if (m_cnt >= m_prd) begin wrap = 1; n_cnt = 0; end
                else n_cnt = m_cnt + 1;
            end else if (!m_dir) begin
                if (m_cnt >= m_prd) begin
                    peak = 1;
                    if (m_cnt <= 1) begin wrap = 1; n_cnt = 0; n_dir = 0; end
                    else begin n_cnt = m_cnt - 1; n_dir = 1; end
                end else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt <= 1) begin wrap = 1; n_cnt = 0; n_dir = 0; end
                else n_cnt = m_cnt - 1;
            end
            mask = (1 << m_ctrl[4:3]) - 1;
            m_irq = m_ctrl[0] && ((wrap && ((int'(m_div) & mask) == mask)) ||
                                  (peak && m_ctrl[5] && m_ctrl[4:3] == 0));
            ld = !m_ctrl[0] || wrap;
            for (int i = 0; i < 3; i++) begin
                raw = m_cnt < m_cmp[i];
                if (!m_ctrl[0]) begin m_lvl[i] = 0; m_run[i] = 0; end
                else begin
                    if (raw != m_lvl[i]) m_run[i] = 0;
                    else if (m_run[i] != 8'hFF) m_run[i] = m_run[i] + 1;
                    m_lvl[i] = raw;
                end
            end
            if (ld) begin
                for (int i = 0; i < 3; i++) m_cmp[i] = m_ctrl[2] ? m_cmp_sh[0] : m_cmp_sh[i];
                m_prd = m_prd_sh;
            end
            if (!m_ctrl[0]) m_div = 0; else if (wrap) m_div = m_div + 1;
            m_cnt = n_cnt; m_dir = n_dir;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        n_ctrl = wr_data[7:0];
                        if (m_ctrl[0]) n_ctrl[7:6] = m_ctrl[7:6];
                        m_ctrl = n_ctrl;
                    end
                    3'd1: m_prd_sh = wr_data;
                    3'd2: m_cmp_sh[0] = wr_data;
                    3'd3: m_cmp_sh[1] = wr_data;
                    3'd4: m_cmp_sh[2] = wr_data;
                    3'd5: m_dt = wr_data[7:0];
                    default: ;
                endcase
            end
        end
        for (int i = 0; i < 3; i++) begin
            e.hi[i] = (m_ctrl[0] && m_lvl[i] && m_run[i] >= m_dt) ^ m_ctrl[6];
            e.lo[i] = (m_ctrl[0] && !m_lvl[i] && m_run[i] >= m_dt) ^ m_ctrl[7];
        end
        e.dir = m_dir; e.irq = m_irq; e.cnt = m_cnt; e.cen = m_ctrl[1];
        q.push_back(e);
    end

    // Monitor: pops one expected item per cycle and compares at the ports.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (rd_addr == 3'd6) check(e.cen ? "R3 counter" : "R2 counter", rd_data, e.cnt);
            check("R4 direction", {11'd0, cnt_down}, {11'd0, e.dir});
            check("R8 irq", {11'd0, irq}, {11'd0, e.irq});
            check("R10 gate_hi", {9'd0, gate_hi}, {9'd0, e.hi});
            check("R10 gate_lo", {9'd0, gate_lo}, {9'd0, e.lo});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        @(negedge clk); #2;
        rd_addr = a; #1;
        d = rd_data;
        rd_addr = 3'd6;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 12'h000);
        end
        check("R1 gates", {6'd0, gate_hi, gate_lo}, 12'h000);
        // R13: counter and status not writable
        scen = "R13";
        wr(3'd6, 12'h055);
        wr(3'd7, 12'h001);
        rd(3'd6, v); check("R13 counter write", v, 12'h000);
        rd(3'd7, v); check("R13 status write", v, 12'h000);
        // R2: edge mode
        scen = "R2";
        wr(3'd1, 12'd9); wr(3'd2, 12'd4); wr(3'd3, 12'd7); wr(3'd4, 12'd2);
        wr(3'd5, 12'd2);
        wr(3'd0, 12'h001);
        run(40);
        // R5 and R6: shadow writes mid-period
        scen = "R5";
        wr(3'd1, 12'd5);
        run(20);
        scen = "R6";
        wr(3'd2, 12'd1);
        run(20);
        // R7: shared duty
        scen = "R7";
        wr(3'd2, 12'd3);
        wr(3'd0, 12'h005);
        run(30);
        // R8: interrupt every 4 periods
        scen = "R8";
        wr(3'd0, 12'h011);
        run(80);
        // R11: stop, then set polarity while stopped
        scen = "R11";
        wr(3'd0, 12'h000);
        run(5);
        check("R11 stopped gate_hi", {9'd0, gate_hi}, 12'h000);
        wr(3'd0, 12'h0C0);
        run(3);
        check("R12 inverted idle", {6'd0, gate_hi, gate_lo}, 12'h03F);
        // R3: center mode
        scen = "R3";
        wr(3'd1, 12'd6); wr(3'd2, 12'd4); wr(3'd3, 12'd2); wr(3'd4, 12'd5);
        wr(3'd0, 12'h0C3);
        run(60);
        // R9: half-period interrupt
        scen = "R9";
        wr(3'd0, 12'h0E3);
        run(60);
        // R12: polarity locked while running
        scen = "R12";
        wr(3'd0, 12'h023);
        rd(3'd0, v); check("R12 polarity lock", v, 12'h0E3);
        run(20);
        // R10: dead time values
        scen = "R10";
        wr(3'd5, 12'd0);
        run(30);
        wr(3'd5, 12'd5);
        run(40);
        // R4: center with decimated interrupt
        scen = "R4";
        wr(3'd5, 12'd1);
        wr(3'd0, 12'h0CB);
        run(50);
        // R11: stop from running
        scen = "R11";
        wr(3'd0, 12'h000);
        run(4);
        rd(3'd6, v); check("R11 counter held", v, 12'h000);
        check("R11 gates off", {6'd0, gate_hi, gate_lo}, 12'h03F);
        run(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule